// File: doc/BRIEF.md
# UART Automatic Hardware Flow Control

This block runs the automatic hardware handshake for one UART channel. On the receive side it drives an active-low request output from the receive FIFO fill level, with hysteresis between two programmable thresholds. This output tells the far end to pause or resume sending. On the transmit side it watches an active-low clear input from the far end. When that input rises, the block withholds permission for the next character. The character already on the line is always allowed to finish through its stop bit.

A single select bit decides which pin pair carries the handshake: the request-to-send / clear-to-send pair, or the data-terminal-ready / data-set-ready pair. Whichever pin is not selected simply follows its software bit. A sticky interrupt status flag reports when a monitored source deasserts. It has a two-level enable and is cleared by a modem-status read strobe. The serial shifter, the baud generator and the FIFO storage sit outside this block. The transmitter tells the block when each character starts and when its stop bit has left.

Top module: `uart_auto_flow`

## Requirements
- R1: After reset, rtsN and dtrN are 1, txAllow is 1, txHalted is 0 and flowIrq is 0.
- R2: Address 1 (modem control) holds bit 0 = request bit, bit 1 = terminal-ready bit and bit 2 = pair select. Select 0 applies the automatic logic to rtsN/ctsN. Select 1 applies it to dtrN/dsrN. The unselected input has no effect on txAllow or flowIrq.
- R3: An output pin follows the inverse of its own software bit, one cycle after the write. The exception is when it is the selected pin, automatic request is enabled (address 0 bit 6) and its software bit is 1.
- R4: Under automatic request, the pin goes high once rxLevel >= upper threshold (address 3). It goes low once rxLevel <= lower threshold (address 4). Between the two it holds its value. The pin changes two cycles after rxLevel changes. The reset thresholds are 48 and 16.
- R5: With automatic clear enabled (address 0 bit 7), a low-to-high change of the selected clear input with no character in flight drops txAllow and raises txHalted three clock edges after the pin changes.
- R6: If a character is in flight (txStart seen, txCharDone not yet seen) when the stop request arrives, txAllow drops but txHalted stays 0. txHalted rises on the edge that samples txCharDone.
- R7: When the selected clear input returns low, txAllow returns to 1 and txHalted to 0 three edges after the pin change.
- R8: With automatic clear disabled, txAllow stays 1 whatever the clear inputs do.
- R9: The interrupt needs master enable address 0 bit 4, together with address 2 bit 7 for the clear source or address 2 bit 6 for the request source. Without both, no source sets flowIrq.
- R10: flowIrq is set by an enabled source: a rising edge of the selected clear input (three edges after the pin changes), or the automatic request pin being driven high (same edge as the pin). It is cleared on the edge after msrRead. A set and a clear in the same cycle leave it set.
- R11: txAllow and txHalted are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| msrRead | input | 1 | Modem-status read strobe, clears flowIrq |
| rxLevel | input | 7 | Receive FIFO fill level |
| txStart | input | 1 | Transmitter began a character |
| txCharDone | input | 1 | Stop bit of current character has left |
| ctsN | input | 1 | Active-low clear-to-send input |
| dsrN | input | 1 | Active-low data-set-ready input |
| rtsN | output | 1 | Active-low request-to-send output |
| dtrN | output | 1 | Active-low terminal-ready output |
| txAllow | output | 1 | Transmitter may start a new character |
| txHalted | output | 1 | Transmission fully stopped at a character boundary |
| flowIrq | output | 1 | Flow-control interrupt status flag |

## Verification
Two functions can land in the same cycle: the sticky interrupt's clear by a modem-status read, and a new set from a freshly detected rising edge on the clear input. The bench provokes this by holding msrRead high in exactly the cycle in which the synchronized edge is evaluated. It then requires flowIrq to be 1 afterwards, and requires a lone read to clear it. A second overlap is a stop request arriving while a character is in flight. Here the bench requires txHalted to wait for the stop-bit strobe, however many cycles pass.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_FEAT  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MODEM = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_IRQEN = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_HITH  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_LOTH  = 3'd4;

  // feature register fields
  localparam int FEAT_AUTO_CLR = 7;
  localparam int FEAT_AUTO_REQ = 6;
  localparam int FEAT_IRQ_MST  = 4;
  // modem control fields
  localparam int MDM_REQ_BIT  = 0;
  localparam int MDM_TERM_BIT = 1;
  localparam int MDM_PAIR_SEL = 2;
  // interrupt enable fields
  localparam int IE_CLR_SRC = 7;
  localparam int IE_REQ_SRC = 6;

  // control -> datapath strobes
  typedef struct packed {
    logic autoReqRts;
    logic autoReqDtr;
    logic manRtsN;
    logic manDtrN;
    logic pairSel;
  } pinCtl_t;

  // datapath -> control events
  typedef struct packed {
    logic clrRise;
    logic clrLevel;
    logic reqDropEvt;
  } flowEvt_t;

  typedef enum logic [1:0] {
    GATE_OPEN  = 2'd0,
    GATE_DRAIN = 2'd1,
    GATE_SHUT  = 2'd2
  } gateState_t;

endpackage

// File: rtl/uart_flow_dp.sv
module uart_flow_dp
  import uart_flow_pkg::*;
#(
  parameter int LEVEL_W     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctsN,
  input  logic               dsrN,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic [LEVEL_W-1:0] hiThr,
  input  logic [LEVEL_W-1:0] loThr,
  input  pinCtl_t            pinCtl,
  output logic               rtsN,
  output logic               dtrN,
  output flowEvt_t           evt
);

  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] pinIn;
  logic [NUM_IN-1:0] syncOut;
  logic [NUM_IN-1:0] syncPrev;
  logic [NUM_IN-1:0] riseDet;

  assign pinIn = {dsrN, ctsN};

  // per-input synchronizer and edge detector
  genvar g;
  generate
    for (g = 0; g < NUM_IN; g++) begin : gSync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          chain       <= '1;
          syncPrev[g] <= 1'b1;
        end else begin
          chain       <= {chain[SYNC_STAGES-2:0], pinIn[g]};
          syncPrev[g] <= chain[SYNC_STAGES-1];
        end
      end
      assign syncOut[g] = chain[SYNC_STAGES-1];
      assign riseDet[g] = chain[SYNC_STAGES-1] & ~syncPrev[g];
    end
  endgenerate

  // receive fill hysteresis
  logic rxFull;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull <= 1'b0;
    end else if (rxLevel >= hiThr) begin
      rxFull <= 1'b1;
    end else if (rxLevel <= loThr) begin
      rxFull <= 1'b0;
    end
  end

  logic rtsNext;
  logic dtrNext;
  always_comb begin
    rtsNext = pinCtl.autoReqRts ? rxFull : pinCtl.manRtsN;
    dtrNext = pinCtl.autoReqDtr ? rxFull : pinCtl.manDtrN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rtsN <= 1'b1;
      dtrN <= 1'b1;
    end else begin
      rtsN <= rtsNext;
      dtrN <= dtrNext;
    end
  end

  always_comb begin
    evt.clrRise    = riseDet[pinCtl.pairSel];
    evt.clrLevel   = syncOut[pinCtl.pairSel];
    evt.reqDropEvt = (pinCtl.autoReqRts & rxFull & ~rtsN) |
                     (pinCtl.autoReqDtr & rxFull & ~dtrN);
  end

endmodule

// File: rtl/uart_flow_ctrl.sv
module uart_flow_ctrl
  import uart_flow_pkg::*;
#(
  parameter int LEVEL_W = 7,
  parameter int DATA_W  = 8,
  parameter int HI_RST  = 48,
  parameter int LO_RST  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               msrRead,
  input  logic               txStart,
  input  logic               txCharDone,
  input  flowEvt_t           evt,
  output pinCtl_t            pinCtl,
  output logic [LEVEL_W-1:0] hiThr,
  output logic [LEVEL_W-1:0] loThr,
  output logic               txAllow,
  output logic               txHalted,
  output logic               flowIrq,
  output logic               autoClrEn,
  output logic               irqMaster
);

  localparam logic [LEVEL_W-1:0] HI_INIT = LEVEL_W'(HI_RST);
  localparam logic [LEVEL_W-1:0] LO_INIT = LEVEL_W'(LO_RST);

  logic autoReqEn;
  logic reqBit;
  logic termBit;
  logic pairSel;
  logic ieClr;
  logic ieReq;

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoClrEn <= 1'b0;
      autoReqEn <= 1'b0;
      irqMaster <= 1'b0;
      reqBit    <= 1'b0;
      termBit   <= 1'b0;
      pairSel   <= 1'b0;
      ieClr     <= 1'b0;
      ieReq     <= 1'b0;
      hiThr     <= HI_INIT;
      loThr     <= LO_INIT;
    end else if (regWr) begin
      case (regAddr)
        ADR_FEAT: begin
          autoClrEn <= regWrData[FEAT_AUTO_CLR];
          autoReqEn <= regWrData[FEAT_AUTO_REQ];
          irqMaster <= regWrData[FEAT_IRQ_MST];
        end
        ADR_MODEM: begin
          reqBit  <= regWrData[MDM_REQ_BIT];
          termBit <= regWrData[MDM_TERM_BIT];
          pairSel <= regWrData[MDM_PAIR_SEL];
        end
        ADR_IRQEN: begin
          ieClr <= regWrData[IE_CLR_SRC];
          ieReq <= regWrData[IE_REQ_SRC];
        end
        ADR_HITH: hiThr <= regWrData[LEVEL_W-1:0];
        ADR_LOTH: loThr <= regWrData[LEVEL_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    pinCtl.autoReqRts = autoReqEn & reqBit  & ~pairSel;
    pinCtl.autoReqDtr = autoReqEn & termBit &  pairSel;
    pinCtl.manRtsN    = ~reqBit;
    pinCtl.manDtrN    = ~termBit;
    pinCtl.pairSel    = pairSel;
  end

  // character tracking and transmit gate
  logic       inFlight;
  logic       inFlightNext;
  gateState_t gateState;
  gateState_t gateNext;

  assign inFlightNext = txStart | (inFlight & ~txCharDone);

  always_comb begin
    gateNext = gateState;
    case (gateState)
      GATE_OPEN: begin
        if (autoClrEn && evt.clrRise) begin
          gateNext = inFlightNext ? GATE_DRAIN : GATE_SHUT;
        end
      end
      GATE_DRAIN: begin
        if (!autoClrEn || !evt.clrLevel) begin
          gateNext = GATE_OPEN;
        end else if (txCharDone) begin
          gateNext = GATE_SHUT;
        end
      end
      GATE_SHUT: begin
        if (!autoClrEn || !evt.clrLevel) begin
          gateNext = GATE_OPEN;
        end
      end
      default: gateNext = GATE_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateState <= GATE_OPEN;
      inFlight  <= 1'b0;
    end else begin
      gateState <= gateNext;
      inFlight  <= inFlightNext;
    end
  end

  assign txAllow  = (gateState == GATE_OPEN);
  assign txHalted = (gateState == GATE_SHUT);

  // sticky interrupt status, set wins over read-clear
  logic irqSet;
  assign irqSet = irqMaster & ((ieClr & evt.clrRise) | (ieReq & evt.reqDropEvt));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flowIrq <= 1'b0;
    end else if (irqSet) begin
      flowIrq <= 1'b1;
    end else if (msrRead) begin
      flowIrq <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_auto_flow.sv
module uart_auto_flow
  import uart_flow_pkg::*;
#(
  parameter int LEVEL_W     = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HI_RST      = 48,
  parameter int LO_RST      = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               msrRead,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic               txStart,
  input  logic               txCharDone,
  input  logic               ctsN,
  input  logic               dsrN,
  output logic               rtsN,
  output logic               dtrN,
  output logic               txAllow,
  output logic               txHalted,
  output logic               flowIrq
);

  pinCtl_t            pinCtl;
  flowEvt_t           evt;
  logic [LEVEL_W-1:0] hiThr;
  logic [LEVEL_W-1:0] loThr;
  logic               autoClrEn;
  logic               irqMaster;

  uart_flow_ctrl #(
    .LEVEL_W (LEVEL_W),
    .DATA_W  (DATA_W),
    .HI_RST  (HI_RST),
    .LO_RST  (LO_RST)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .msrRead    (msrRead),
    .txStart    (txStart),
    .txCharDone (txCharDone),
    .evt        (evt),
    .pinCtl     (pinCtl),
    .hiThr      (hiThr),
    .loThr      (loThr),
    .txAllow    (txAllow),
    .txHalted   (txHalted),
    .flowIrq    (flowIrq),
    .autoClrEn  (autoClrEn),
    .irqMaster  (irqMaster)
  );

  uart_flow_dp #(
    .LEVEL_W     (LEVEL_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctsN    (ctsN),
    .dsrN    (dsrN),
    .rxLevel (rxLevel),
    .hiThr   (hiThr),
    .loThr   (loThr),
    .pinCtl  (pinCtl),
    .rtsN    (rtsN),
    .dtrN    (dtrN),
    .evt     (evt)
  );

endmodule

// File: rtl/uart_auto_flow_chk.sv
module uart_auto_flow_chk (
  input logic clk,
  input logic rstN,
  input logic txAllow,
  input logic txHalted,
  input logic txCharDone,
  input logic msrRead,
  input logic flowIrq,
  input logic rtsN,
  input logic dtrN,
  input logic autoClrEn,
  input logic irqMaster,
  input logic clrLevel,
  input logic autoReqRts,
  input logic autoReqDtr,
  input logic manRtsN,
  input logic manDtrN
);

  AST_GATE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(txAllow && txHalted)); // R11

  AST_GATE_OFF_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    !autoClrEn |=> txAllow); // R8

  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!txAllow && !txHalted && !txCharDone && autoClrEn && clrLevel) |=> !txHalted); // R6

  AST_RESUME_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    !clrLevel |=> txAllow); // R7

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (flowIrq && !msrRead) |=> flowIrq); // R10

  AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flowIrq) |-> $past(irqMaster)); // R9

  AST_RTS_MANUAL: assert property (@(posedge clk) disable iff (!rstN)
    !autoReqRts |=> (rtsN == $past(manRtsN))); // R3

  AST_DTR_MANUAL: assert property (@(posedge clk) disable iff (!rstN)
    !autoReqDtr |=> (dtrN == $past(manDtrN))); // R3

endmodule

bind uart_auto_flow uart_auto_flow_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .txAllow    (txAllow),
  .txHalted   (txHalted),
  .txCharDone (txCharDone),
  .msrRead    (msrRead),
  .flowIrq    (flowIrq),
  .rtsN       (rtsN),
  .dtrN       (dtrN),
  .autoClrEn  (autoClrEn),
  .irqMaster  (irqMaster),
  .clrLevel   (evt.clrLevel),
  .autoReqRts (pinCtl.autoReqRts),
  .autoReqDtr (pinCtl.autoReqDtr),
  .manRtsN    (pinCtl.manRtsN),
  .manDtrN    (pinCtl.manDtrN)
);

// File: tb/tb_uart_auto_flow.sv
`timescale 1ns/1ps
module tb_uart_auto_flow;

  localparam int LEVEL_W = 7;
  localparam int MAX_LVL = 64;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               regWr = 1'b0;
  logic [2:0]         regAddr = '0;
  logic [7:0]         regWrData = '0;
  logic               msrRead = 1'b0;
  logic [LEVEL_W-1:0] rxLevel = '0;
  logic               txStart = 1'b0;
  logic               txCharDone = 1'b0;
  logic               ctsN = 1'b0;
  logic               dsrN = 1'b0;
  logic               rtsN, dtrN, txAllow, txHalted, flowIrq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  uart_auto_flow dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .msrRead(msrRead), .rxLevel(rxLevel),
    .txStart(txStart), .txCharDone(txCharDone), .ctsN(ctsN), .dsrN(dsrN),
    .rtsN(rtsN), .dtrN(dtrN), .txAllow(txAllow), .txHalted(txHalted),
    .flowIrq(flowIrq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regWr = 1'b1; regAddr = a; regWrData = d;
    edges(1);
    regWr = 1'b0;
  endtask

  task automatic setClr(input logic sel, input logic v);
    if (sel) dsrN = v; else ctsN = v;
  endtask

  task automatic msrPulse();
    msrRead = 1'b1;
    edges(1);
    msrRead = 1'b0;
  endtask

  // hysteresis sweep, R2 R3 R4
  task automatic sweep(input logic sel, input logic autoEn, input logic rB,
                       input logic dB, input int hi, input int lo);
    logic full;
    logic expR, expD;
    wr(3'd3, 8'(hi));
    wr(3'd4, 8'(lo));
    rxLevel = '0;
    wr(3'd0, autoEn ? 8'h40 : 8'h00);
    wr(3'd1, {5'd0, sel, dB, rB});
    edges(2);
    full = 1'b0;
    for (int step = 0; step <= 2 * MAX_LVL; step++) begin
      int lvl;
      lvl = (step <= MAX_LVL) ? step : 2 * MAX_LVL - step;
      rxLevel = LEVEL_W'(lvl);
      if (lvl >= hi) full = 1'b1;
      else if (lvl <= lo) full = 1'b0;
      edges(2);
      expR = (autoEn && rB && !sel) ? full : !rB;
      expD = (autoEn && dB &&  sel) ? full : !dB;
      chk($sformatf("R4 rtsN lvl=%0d sel=%0b", lvl, sel), rtsN, expR);
      chk($sformatf("R3 dtrN lvl=%0d sel=%0b", lvl, sel), dtrN, expD);
    end
    rxLevel = '0;
    edges(2);
  endtask

  // transmit gating for one pair, R5 R6 R7 R2
  task automatic gateTest(input logic sel);
    wr(3'd1, {5'd0, sel, 2'b00});
    wr(3'd0, 8'h80);
    ctsN = 1'b0; dsrN = 1'b0;
    edges(4);
    // unselected input ignored
    setClr(!sel, 1'b1);
    edges(4);
    chk("R2 unselected input ignored", txAllow, 1'b1);
    setClr(!sel, 1'b0);
    edges(4);
    // idle stop
    setClr(sel, 1'b1);
    edges(2);
    chk("R5 allow before sync settles", txAllow, 1'b1);
    edges(1);
    chk("R5 allow drops", txAllow, 1'b0);
    chk("R5 halted idle", txHalted, 1'b1);
    setClr(sel, 1'b0);
    edges(2);
    chk("R7 still stopped", txAllow, 1'b0);
    edges(1);
    chk("R7 resume allow", txAllow, 1'b1);
    chk("R7 resume halted", txHalted, 1'b0);
    // in-flight stop
    txStart = 1'b1;
    edges(1);
    txStart = 1'b0;
    setClr(sel, 1'b1);
    edges(3);
    chk("R6 allow drops in flight", txAllow, 1'b0);
    chk("R6 not halted in flight", txHalted, 1'b0);
    chk("R11 exclusive", txAllow & txHalted, 1'b0);
    edges(6);
    chk("R6 waits for stop bit", txHalted, 1'b0);
    txCharDone = 1'b1;
    edges(1);
    txCharDone = 1'b0;
    chk("R6 halted after stop bit", txHalted, 1'b1);
    setClr(sel, 1'b0);
    edges(3);
    chk("R7 resume after drain", txAllow, 1'b1);
    // disabled
    wr(3'd0, 8'h00);
    setClr(sel, 1'b1);
    edges(5);
    chk("R8 disabled stays allowed", txAllow, 1'b1);
    chk("R8 disabled not halted", txHalted, 1'b0);
    setClr(sel, 1'b0);
    edges(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    edges(3);
    chk("R1 reset rtsN", rtsN, 1'b1);
    chk("R1 reset dtrN", dtrN, 1'b1);
    chk("R1 reset txAllow", txAllow, 1'b1);
    chk("R1 reset txHalted", txHalted, 1'b0);
    chk("R1 reset flowIrq", flowIrq, 1'b0);
    rstN = 1'b1;
    edges(2);
    chk("R1 after release rtsN", rtsN, 1'b1);

    for (int sel = 0; sel < 2; sel++) begin
      sweep(sel[0], 1'b1, 1'b1, 1'b1, 48, 16);
      sweep(sel[0], 1'b1, 1'b0, 1'b0, 48, 16);
      sweep(sel[0], 1'b0, 1'b1, 1'b0, 48, 16);
      sweep(sel[0], 1'b1, 1'b1, 1'b0, 40, 10);
    end

    gateTest(1'b0);
    gateTest(1'b1);

    // interrupt enables, R9
    wr(3'd1, 8'h00);
    wr(3'd2, 8'hC0);
    wr(3'd0, 8'h00);
    ctsN = 1'b1;
    edges(5);
    chk("R9 no master no irq", flowIrq, 1'b0);
    ctsN = 1'b0;
    edges(4);
    wr(3'd0, 8'h10);
    wr(3'd2, 8'h00);
    ctsN = 1'b1;
    edges(5);
    chk("R9 no source enable no irq", flowIrq, 1'b0);
    ctsN = 1'b0;
    edges(4);

    // clear-source interrupt, R10
    wr(3'd2, 8'h80);
    ctsN = 1'b1;
    edges(2);
    chk("R10 irq not yet", flowIrq, 1'b0);
    edges(1);
    chk("R10 irq on clear rise", flowIrq, 1'b1);
    edges(3);
    chk("R10 irq sticky", flowIrq, 1'b1);
    msrPulse();
    chk("R10 irq cleared by read", flowIrq, 1'b0);
    ctsN = 1'b0;
    edges(4);
    // collision: read in the cycle of the new set
    ctsN = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    msrRead = 1'b1;
    edges(1);
    msrRead = 1'b0;
    chk("R10 set wins over read", flowIrq, 1'b1);
    msrPulse();
    chk("R10 lone read clears", flowIrq, 1'b0);
    ctsN = 1'b0;
    edges(4);

    // request-source interrupt, R9 R10
    rxLevel = '0;
    wr(3'd0, 8'h50);
    wr(3'd1, 8'h01);
    wr(3'd2, 8'h80);
    edges(2);
    rxLevel = LEVEL_W'(48);
    edges(2);
    chk("R4 rts high at threshold", rtsN, 1'b1);
    chk("R9 req source not enabled", flowIrq, 1'b0);
    rxLevel = '0;
    edges(3);
    chk("R4 rts low after drain", rtsN, 1'b0);
    wr(3'd2, 8'h40);
    rxLevel = LEVEL_W'(50);
    edges(1);
    chk("R10 req irq not yet", flowIrq, 1'b0);
    edges(1);
    chk("R10 req irq with pin", flowIrq, 1'b1);
    chk("R4 rts high", rtsN, 1'b1);
    msrPulse();
    chk("R10 req irq cleared", flowIrq, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule